// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides a double-width unsigned dividend by a single-width unsigned divisor. It works over several clock cycles and produces a single-width quotient and remainder. The caller presents both operands and pulses `start` while the block is idle. The block copies the operands into its own registers and then runs one shift/subtract step per clock, settling one quotient bit per step, most significant bit first. When the last bit is settled it pulses `done`. The quotient and remainder then hold their values until the next accepted start.

Each step shifts the partial remainder left by one place and brings in the next dividend bit. It then tries to subtract the divisor. If the difference is non-negative, the difference is kept and the quotient bit is 1. Otherwise the shifted value is kept and the bit is 0. The subtraction is one bit wider than the divisor, so the bit pushed out of the top of the partial remainder still takes part in the comparison.

A result fits in the quotient width only when the dividend's upper half is below the divisor. If that does not hold when a start is accepted, the block does not divide. It raises an error flag, and this covers a zero divisor. The operand width is the parameter `K`.

Top module: `div_restoring`

## Requirements
- R1: With dividend `z` of 2K bits, divisor `d` of K bits and `z[2K-1:K] < d`, the block gives `quotient = z / d` and `remainder = z % d` (integer division). For example, with K=4, z=117 and d=10 give 11 and 7.
- R2: Once a division is accepted, every partial remainder it produces is below the latched divisor, so the final remainder is always less than `d`.
- R3: `done` is high for exactly one cycle. It rises in the cycle that follows the K-th clock edge after the edge that accepted `start`.
- R4: A `start` seen while a division is in progress is ignored, together with any operand change at that time. The running division completes with its original operands and its original timing.
- R5: If `z[2K-1:K] >= d` (this includes d=0) at an accepted start, `divErr` is 1 in the next cycle and `done` does not assert. `quotient` and `remainder` keep their previous values.
- R6: `divErr` holds until the next accepted start. That start clears it when its operands are valid.
- R7: `quotient` and `remainder` do not change while the block is idle and no start is given.
- R8: After synchronous reset (`rst` high at a clock edge), `done`, `divErr`, `quotient` and `remainder` are all 0 and the block is idle.
- R9: The result is still correct when the divisor's top bit is set and the shifted partial remainder overflows K bits. For example, with K=4, z=239 and d=15 give 15 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division; sampled only when idle |
| dividend | input | 2K | Unsigned dividend z |
| divisor | input | K | Unsigned divisor d |
| quotient | output | K | Unsigned quotient q |
| remainder | output | K | Unsigned remainder r |
| done | output | 1 | One-cycle pulse when a result is ready |
| divErr | output | 1 | Set when the operands at an accepted start would overflow the quotient |

## Verification
The error flag is due one edge after the accepting edge. `done`, the quotient and the remainder are due K edges after that, and `done` must drop again on the edge after that. The bench drives each start half a cycle before the accepting edge. It then steps on falling edges and counts exactly K+1 of them to the `done` sample. In every intermediate cycle it confirms that `done` is still low, and in the cycle after `done` that the pulse has ended and the results are unchanged. For overflowing operand pairs it watches the same window of K+1 cycles and confirms that no `done` appears and that the previous results remain in place.

// File: rtl/div_pkg.sv
package div_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture operands
    logic step;   // perform one shift/subtract iteration
  } div_strobe_t;
endpackage

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int K = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  div_strobe_t   strobe,
  input  logic [2*K-1:0] dividend,
  input  logic [K-1:0]  divisor,
  output logic          tooBig,
  output logic [K-1:0]  quotient,
  output logic [K-1:0]  remainder
);
  localparam int W = K + 1;

  logic [K-1:0] remReg;
  logic [K-1:0] lowReg;
  logic [K-1:0] divReg;
  logic [W-1:0] shifted;
  logic [W-1:0] diff;
  logic         qBit;

  // Quotient would need more than K bits (covers a zero divisor).
  assign tooBig = dividend[2*K-1:K] >= divisor;

  // Shift in the next dividend bit; keep the carried-out top bit.
  assign shifted = {remReg, lowReg[K-1]};
  assign diff    = shifted - {1'b0, divReg};
  assign qBit    = ~diff[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg <= '0;
      lowReg <= '0;
      divReg <= '0;
    end else if (strobe.load) begin
      remReg <= dividend[2*K-1:K];
      lowReg <= dividend[K-1:0];
      divReg <= divisor;
    end else if (strobe.step) begin
      remReg <= qBit ? diff[K-1:0] : shifted[K-1:0];
      lowReg <= {lowReg[K-2:0], qBit};
    end
  end

  assign quotient  = lowReg;
  assign remainder = remReg;

  // R2: each iteration leaves a partial remainder below the divisor.
  assert_rem_below_div_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> (remReg < divReg));

  // R4: the latched divisor is untouched while iterating.
  assert_div_held_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> $stable(divReg));
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int K = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        tooBig,
  output div_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        divErr
);
  localparam int CW = $clog2(K + 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t        state;
  logic [CW-1:0] stepCnt;

  assign busy        = (state == S_RUN);
  assign strobe.load = (state == S_IDLE) && start && !tooBig;
  assign strobe.step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
      divErr  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            divErr <= tooBig;
            if (!tooBig) begin
              state   <= S_RUN;
              stepCnt <= '0;
            end
          end
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(K - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: completion is a single-cycle pulse.
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: the iteration count never passes K.
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (stepCnt < CW'(K)));

  // R5: an overflow never produces a result.
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    divErr |-> !done);
endmodule

// File: rtl/div_restoring.sv
module div_restoring
  import div_pkg::*;
#(
  parameter int K = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*K-1:0] dividend,
  input  logic [K-1:0]   divisor,
  output logic [K-1:0]   quotient,
  output logic [K-1:0]   remainder,
  output logic           done,
  output logic           divErr
);
  div_strobe_t strobe;
  logic        tooBig;
  logic        busy;

  div_ctrl #(.K(K)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .tooBig (tooBig),
    .strobe (strobe),
    .busy   (busy),
    .done   (done),
    .divErr (divErr)
  );

  div_datapath #(.K(K)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .dividend  (dividend),
    .divisor   (divisor),
    .tooBig    (tooBig),
    .quotient  (quotient),
    .remainder (remainder)
  );

  // R7: results hold while idle without a start.
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/test_div_restoring.sv
`timescale 1ns/1ps
module test_div_restoring;
  localparam int K = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [2*K-1:0] dividend = '0;
  logic [K-1:0]   divisor = '0;
  logic [K-1:0]   quotient, remainder;
  logic           done, divErr;

  int nVec = 0;
  int nBad = 0;
  int prevQ = 0;
  int prevR = 0;

  always #2.5 clk = ~clk;

  div_restoring #(.K(K)) i_div_restoring (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done), .divErr(divErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d (z=%0d d=%0d)", tag, act, exp, dividend, divisor);
    end
  endtask

  task automatic runOne(input int z, input int d, input bit interrupt);
    int eq, er;
    string tagV;
    @(negedge clk);
    dividend = (2*K)'(z);
    divisor  = K'(d);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if ((z >> K) >= d) begin
      check(divErr == 1'b1, "R5 divErr", int'(divErr), 1);
      for (int j = 1; j <= K + 1; j++) begin
        @(negedge clk);
        check(done == 1'b0, "R5 no done", int'(done), 0);
      end
      check(int'(quotient) == prevQ, "R5 quotient held", int'(quotient), prevQ);
      check(int'(remainder) == prevR, "R5 remainder held", int'(remainder), prevR);
      check(divErr == 1'b1, "R6 divErr held", int'(divErr), 1);
      return;
    end
    check(divErr == 1'b0, "R6 divErr cleared", int'(divErr), 0);
    check(done == 1'b0, "R3 done early", int'(done), 0);
    eq = z / d;
    er = z % d;
    tagV = (d >= (1 << (K - 1))) ? "R9" : "R1";
    for (int j = 1; j <= K; j++) begin
      if (interrupt && j == 1) begin
        // R4: start with other operands while busy
        start    = 1'b1;
        dividend = ~dividend;
        divisor  = divisor ^ K'(1);
      end
      @(negedge clk);
      start = 1'b0;
      if (j < K) check(done == 1'b0, "R3 done early", int'(done), 0);
    end
    check(done == 1'b1, "R3 done due", int'(done), 1);
    check(int'(quotient) == eq, interrupt ? "R4 quotient" : {tagV, " quotient"}, int'(quotient), eq);
    check(int'(remainder) == er, interrupt ? "R4 remainder" : {tagV, " remainder"}, int'(remainder), er);
    check(int'(remainder) < d, "R2 remainder < d", int'(remainder), d);
    @(negedge clk);
    check(done == 1'b0, "R3 single pulse", int'(done), 0);
    check(int'(quotient) == eq, "R7 quotient stable", int'(quotient), eq);
    check(int'(remainder) == er, "R7 remainder stable", int'(remainder), er);
    prevQ = eq;
    prevR = er;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check(done == 1'b0, "R8 done", int'(done), 0);
    check(divErr == 1'b0, "R8 divErr", int'(divErr), 0);
    check(quotient == '0, "R8 quotient", int'(quotient), 0);
    check(remainder == '0, "R8 remainder", int'(remainder), 0);
    // R1 worked example, R9 carry example
    runOne(117, 10, 1'b0);
    runOne(239, 15, 1'b0);
    // Near-exhaustive sweep including overflow and zero divisor (R5)
    for (int d = 0; d < (1 << K); d++)
      for (int z = 0; z < (1 << (2*K)); z++)
        runOne(z, d, (z % 7) == 3);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #900_000;
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule